// File: doc/BRIEF.md
# RTC Square-Wave and Alarm Pin Controller

This block owns the 8-bit control register of a real-time clock and decides what the shared square-wave/interrupt pin does. It runs on the 32.768 kHz oscillator clock. It sees a main-supply-valid flag and a one-cycle alarm-match pulse from the timekeeping compare logic. Software reaches the register through plain address/data strobes. From the register fields, the block can send the pin a square wave at one of four rates, or an active-low alarm interrupt. It can also leave the pin undriven. The block also keeps the sticky alarm flag and drives the oscillator-enable output.

A small state machine picks the pin mode and registers it. It has three states:
- `PM_HIZ`: the pin is undriven.
- `PM_WAVE`: the pin carries the selected square wave.
- `PM_INT`: the pin carries the alarm interrupt.

On every clock the state is recomputed, and the transitions are named as follows:
- "supply-loss release" goes to `PM_HIZ` when the main supply is invalid and the backup-drive bit is clear.
- "interrupt select" goes to `PM_INT` when the interrupt-control bit is set and the pin is allowed to drive.
- "wave select" goes to `PM_WAVE` in the remaining cases.

Each state also holds itself when its condition persists. A new mode takes effect on the clock edge after the inputs that select it.

The square-wave rates come from a 15-bit counter. The counter is held at zero whenever the oscillator is stopped, so each waveform restarts in a known phase.

Top module: `rtc_sqw_alarm_ctrl`

## Requirements
- R1: While reset is asserted, the control register reads 0x18, the alarm flag is 0 and `pin_oe` is 0.
- R2: Writes with `acc_addr` = 0x8D load the register. A write to any other address leaves the register unchanged. `rd_data` shows the register only while `acc_rd` is 1 and `acc_addr` = 0x0D; otherwise it is 0x00.
- R3: The register fields are as follows:
  - bit 7 is oscillator-stop-on-backup;
  - bit 5 is backup-drive;
  - bits 4:3 are the rate select;
  - bit 2 is interrupt-control;
  - bit 0 is alarm-interrupt-enable;
  - bits 6 and 1 always read 0, whatever was written (0xFF reads back as 0xBD).
- R4: `osc_en` is 1 whenever `vcc_ok` is 1. It is 0 only when `vcc_ok` is 0 and bit 7 is 1.
- R5: With the pin in wave mode and the oscillator running, the rate select works as follows:
  - 00 gives a 50% duty wave with a period of 32768 clocks;
  - 01 gives a wave with a period of 8 clocks;
  - 10 gives a wave with a period of 4 clocks;
  - 11 passes the oscillator clock itself (high while `clk` is high).
- R6: When bit 2 is 0 and the pin is driven, it carries the wave while `osc_en` is 1, and is held high while `osc_en` is 0.
- R7: When bit 2 is 1 and the pin is driven, `pin_val` is 0 exactly when bit 0 and the alarm flag are both 1; otherwise it is 1.
- R8: The alarm flag is set on every `alarm_match` pulse, whatever the register holds. `flag_clr` clears it. If both arrive in the same cycle, the set wins.
- R9: One clock after `vcc_ok` = 0 with bit 5 = 0, `pin_oe` is 0. One clock after `vcc_ok` = 1, or bit 5 = 1, `pin_oe` is 1.
- R10: While `osc_en` is 0 the rate counter is held at zero. When the oscillator resumes with rate select 00, the first sample of `pin_val` that is high comes after the 16384th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_ok | input | 1 | Main supply is above the power-fail trip point |
| alarm_match | input | 1 | One-cycle pulse on an alarm compare hit |
| flag_clr | input | 1 | One-cycle strobe that clears the alarm flag |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read enable |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when not selected |
| alarm_flag | output | 1 | Sticky alarm flag |
| osc_en | output | 1 | Oscillator enable |
| pin_oe | output | 1 | Drive enable of the square-wave/interrupt pin |
| pin_val | output | 1 | Value driven on the pin (interrupt active low) |

## Verification
The assertions rely on a few properties of the inputs:
- `alarm_match`, `flag_clr`, `vcc_ok` and the access strobes are synchronous to `clk`.
- A match or clear lasts exactly one cycle.
- A write strobe lasts a single cycle.

The stimulus meets these by changing every input on the falling clock edge. Each pulse is held for exactly one clock period. The supply flag only changes while no access is in flight. The outputs are sampled a few nanoseconds after an edge, never on it. This lets the 32.768 kHz pass-through rate be observed in both clock phases.

// File: rtl/rtc_sqw_pkg.sv
package rtc_sqw_pkg;

    // pin drive modes held by the output state machine
    typedef enum logic [1:0] {
        PM_HIZ  = 2'd0,
        PM_WAVE = 2'd1,
        PM_INT  = 2'd2
    } pin_mode_e;

    localparam logic [7:0] CTRL_RD_ADDR = 8'h0D;
    localparam logic [7:0] CTRL_WR_ADDR = 8'h8D;
    localparam logic [7:0] CTRL_RST_VAL = 8'h18;
    localparam logic [7:0] CTRL_KEEP    = 8'hBD;

    // control field positions (decoded by neighbouring logic)
    localparam int B_OSC_STOP = 7;
    localparam int B_BK_DRIVE = 5;
    localparam int B_RATE_HI  = 4;
    localparam int B_RATE_LO  = 3;
    localparam int B_INT_SEL  = 2;
    localparam int B_IRQ_EN   = 0;

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_sqw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_ok,
    input  logic          alarm_match,
    input  logic          flag_clr,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [DW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctrl_q,
    output logic          alarm_flag,
    output logic          osc_en
);

    logic wr_hit;
    assign wr_hit = acc_wr && (acc_addr == CTRL_WR_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST_VAL;
        end else if (wr_hit) begin
            ctrl_q <= acc_wdata & CTRL_KEEP;
        end
    end

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
        end else if (alarm_match) begin
            alarm_flag <= 1'b1;
        end else if (flag_clr) begin
            alarm_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc_rd && (acc_addr == CTRL_RD_ADDR)) begin
            rd_data = ctrl_q;
        end
    end

    assign osc_en = vcc_ok || !ctrl_q[B_OSC_STOP];

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_match |=> alarm_flag);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !alarm_match) |=> !alarm_flag);

    // R4
    osc_mains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_ok |-> osc_en);

endmodule

// File: rtl/rtc_wave_div.sv
module rtc_wave_div #(
    parameter int CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [1:0] rate_sel,
    output logic       wave
);

    localparam int TAP_SLOW = CNT_W - 1;
    localparam int TAP_DIV4 = 1;
    localparam int TAP_DIV8 = 2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!osc_en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (rate_sel)
            2'b00:   wave = cnt_q[TAP_SLOW];
            2'b01:   wave = cnt_q[TAP_DIV8];
            2'b10:   wave = cnt_q[TAP_DIV4];
            default: wave = clk;
        endcase
    end

    // R10
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_pin_fsm.sv
module rtc_pin_fsm
    import rtc_sqw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic bk_drive,
    input  logic int_sel,
    input  logic irq_en,
    input  logic alarm_flag,
    input  logic osc_en,
    input  logic wave,
    output logic pin_oe,
    output logic pin_val
);

    pin_mode_e state_q, state_d;

    always_comb begin
        if (!vcc_ok && !bk_drive) begin
            state_d = PM_HIZ;      // supply-loss release
        end else if (int_sel) begin
            state_d = PM_INT;      // interrupt select
        end else begin
            state_d = PM_WAVE;     // wave select
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_HIZ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PM_WAVE: begin
                pin_oe  = 1'b1;
                pin_val = osc_en ? wave : 1'b1;
            end
            PM_INT: begin
                pin_oe  = 1'b1;
                pin_val = !(irq_en && alarm_flag);
            end
            default: begin
                pin_oe  = 1'b0;
                pin_val = 1'b1;
            end
        endcase
    end

    // R9
    hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok && !bk_drive) |=> !pin_oe);

    // R9
    drive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok || bk_drive) |=> pin_oe);

endmodule

// File: rtl/rtc_sqw_alarm_ctrl.sv
module rtc_sqw_alarm_ctrl
    import rtc_sqw_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_ok,
    input  logic          alarm_match,
    input  logic          flag_clr,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [DW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rd_data,
    output logic          alarm_flag,
    output logic          osc_en,
    output logic          pin_oe,
    output logic          pin_val
);

    logic [DW-1:0] ctrl_q;
    logic          wave;

    rtc_ctrl_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .vcc_ok      (vcc_ok),
        .alarm_match (alarm_match),
        .flag_clr    (flag_clr),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .rd_data     (rd_data),
        .ctrl_q      (ctrl_q),
        .alarm_flag  (alarm_flag),
        .osc_en      (osc_en)
    );

    rtc_wave_div #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .rate_sel (ctrl_q[B_RATE_HI:B_RATE_LO]),
        .wave     (wave)
    );

    rtc_pin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_ok     (vcc_ok),
        .bk_drive   (ctrl_q[B_BK_DRIVE]),
        .int_sel    (ctrl_q[B_INT_SEL]),
        .irq_en     (ctrl_q[B_IRQ_EN]),
        .alarm_flag (alarm_flag),
        .osc_en     (osc_en),
        .wave       (wave),
        .pin_oe     (pin_oe),
        .pin_val    (pin_val)
    );

endmodule

// File: tb/tb_rtc_sqw_alarm_ctrl.sv
module tb_rtc_sqw_alarm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_ok = 1'b1;
    logic       alarm_match = 1'b0;
    logic       flag_clr = 1'b0;
    logic       acc_wr = 1'b0;
    logic       acc_rd = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       alarm_flag, osc_en, pin_oe, pin_val;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rtc_sqw_alarm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .alarm_match(alarm_match),
        .flag_clr(flag_clr), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .alarm_flag(alarm_flag), .osc_en(osc_en), .pin_oe(pin_oe),
        .pin_val(pin_val)
    );

    // {vcc, ctrl[7:0], match, exp_oe, exp_val, exp_osc, exp_flag}
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 8'h05, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'h04, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'h05, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'h25, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'hA0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h85, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 8'h85, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = addr; acc_wdata = data;
        @(negedge clk);
        acc_wr = 1'b0; acc_addr = 8'h00;
    endtask

    task automatic rd_reg(input logic [7:0] addr, output logic [7:0] data);
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = addr;
        #1 data = rd_data;
        acc_rd = 1'b0; acc_addr = 8'h00;
    endtask

    task automatic pulse_match();
        @(negedge clk); alarm_match = 1'b1;
        @(negedge clk); alarm_match = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk); #1;
    endtask

    // count rising samples of pin_val across 64 clock intervals
    task automatic count_rises(output int rises);
        logic prev;
        rises = 0;
        @(posedge clk); #3 prev = pin_val;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #3;
            if (pin_val && !prev) rises++;
            prev = pin_val;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int k, hi, rises;

        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        check(pin_oe == 1'b0, "R1 pin_oe in reset", pin_oe, 0);
        check(alarm_flag == 1'b0, "R1 flag in reset", alarm_flag, 0);
        rd_reg(8'h0D, rv);
        check(rv == 8'h18, "R1 ctrl reset value", rv, 8'h18);
        @(negedge clk); rst_n = 1'b1;

        // vector table: R4 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            pulse_clr();
            @(negedge clk); vcc_ok = VEC[v][13];
            wr_reg(8'h8D, VEC[v][12:5]);
            if (VEC[v][4]) pulse_match();
            settle();
            check(pin_oe == VEC[v][3], $sformatf("R9 vec%0d pin_oe", v), pin_oe, VEC[v][3]);
            if (VEC[v][3])
                check(pin_val == VEC[v][2], $sformatf("R7 vec%0d pin_val", v), pin_val, VEC[v][2]);
            check(osc_en == VEC[v][1], $sformatf("R4 vec%0d osc_en", v), osc_en, VEC[v][1]);
            check(alarm_flag == VEC[v][0], $sformatf("R8 vec%0d flag", v), alarm_flag, VEC[v][0]);
        end

        @(negedge clk); vcc_ok = 1'b1;
        pulse_clr();

        // R3 reserved bits
        wr_reg(8'h8D, 8'hFF);
        rd_reg(8'h0D, rv);
        check(rv == 8'hBD, "R3 reserved bits read zero", rv, 8'hBD);

        // R2 address decode
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0D, rv);
        check(rv == 8'hBD, "R2 write at read address ignored", rv, 8'hBD);
        rd_reg(8'h8D, rv);
        check(rv == 8'h00, "R2 read at write address is zero", rv, 0);
        wr_reg(8'h8D, 8'h05);
        rd_reg(8'h0D, rv);
        check(rv == 8'h05, "R2 write at 0x8D", rv, 8'h05);

        // R8 set wins over clear, then clear alone
        @(negedge clk); alarm_match = 1'b1; flag_clr = 1'b1;
        @(negedge clk); alarm_match = 1'b0; flag_clr = 1'b0;
        #1;
        check(alarm_flag == 1'b1, "R8 set beats clear", alarm_flag, 1);
        check(pin_val == 1'b0, "R7 irq asserted low", pin_val, 0);
        pulse_clr();
        #1;
        check(alarm_flag == 1'b0, "R8 clear strobe", alarm_flag, 0);
        check(pin_val == 1'b1, "R7 irq released", pin_val, 1);

        // R5 rates
        wr_reg(8'h8D, 8'h08);
        settle();
        count_rises(rises);
        check(rises == 8, "R5 rate 01 period 8", rises, 8);
        @(negedge clk);
        wr_reg(8'h8D, 8'h10);
        settle();
        count_rises(rises);
        check(rises == 16, "R5 rate 10 period 4", rises, 16);
        @(negedge clk);
        wr_reg(8'h8D, 8'h18);
        settle();
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #3;
            check(pin_val == 1'b1, "R5 rate 11 high phase", pin_val, 1);
            @(negedge clk); #3;
            check(pin_val == 1'b0, "R5 rate 11 low phase", pin_val, 0);
        end

        // R10 stopped oscillator, then in-phase restart at 1 Hz
        @(negedge clk); vcc_ok = 1'b0;
        wr_reg(8'h8D, 8'hA0);
        settle();
        check(osc_en == 1'b0, "R4 oscillator stopped on backup", osc_en, 0);
        check(pin_val == 1'b1, "R6 wave held high while stopped", pin_val, 1);
        @(negedge clk); vcc_ok = 1'b1;
        k = 0;
        for (int i = 1; i <= 20000; i++) begin
            @(posedge clk); #3;
            if (pin_val) begin k = i; break; end
        end
        check(k == 16384, "R10 first high after restart", k, 16384);
        hi = 1;
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk); #3;
            if (pin_val) hi++;
            else break;
        end
        check(hi == 16384, "R5 1 Hz high half length", hi, 16384);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule